// File: doc/BRIEF.md
# ROM Patch Address Comparator

This block lets firmware in a mask-programmed ROM be fixed in the field. It holds a small set of patch entries. Each entry is a 16-bit code address with its own enable bit. Every instruction fetch is compared against the enabled entries. When a fetch lands on a patched location, the block raises a redirect request in the same cycle. The core then branches to a fixed handler address, where replacement code lives in writable memory.

Software programs the entries through a word-wide register port. It first loads an entry while that entry is disabled, then sets the entry's enable bit. Addresses below a guard floor hold the interrupt vectors and the call table, and they must never be patched. The block refuses to match such an entry and records the mistake in a sticky error flag.

Top module: `rom_patch_cmp`

## Requirements
- R1: After reset, both patch address registers read 0000H, the control register reads 0000H and `redir_req` is low.
- R2: Patch entry 0 is read and written as a whole 16-bit word at bus address FF38H, and entry 1 at FF3AH. The odd addresses FF39H and FF3BH, and any other unmapped address, read as 0000H and ignore writes.
- R3: The control register is at bus address FF36H. Bit 1 enables entry 0, bit 3 enables entry 1 and bit 7 is the error flag. All other bits read as 0 and ignore writes.
- R4: A write to a patch address register is ignored while that entry's enable bit is 1. The register keeps its old value.
- R5: While `fetch_valid` is high, an enabled entry whose address equals `fetch_addr` and is at least 0080H raises `redir_req` in the same cycle. `redir_target` is F7FDH. When both entries match, a single one-bit request is raised.
- R6: `redir_req` is low whenever `fetch_valid` is low, and low for an address that matches only a disabled entry.
- R7: An enabled entry whose address is below 0080H never matches. One cycle after such an entry becomes enabled, control bit 7 reads 1.
- R8: Control bit 7 is sticky. Writing 1 to bit 7 clears it. The clear is overridden if an enabled entry below 0080H exists in the cycle of the write.
- R9: A register write takes effect at the clock edge that ends its cycle. A fetch compared in the same cycle as the write uses the values held before the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 16 | Register port address |
| bus_wdata | input | 16 | Register port write data |
| bus_we | input | 1 | Write strobe, one word per cycle |
| bus_rdata | output | 16 | Register port read data, combinational from `bus_addr` |
| fetch_addr | input | 16 | Address of the current instruction fetch |
| fetch_valid | input | 1 | Fetch strobe qualifying `fetch_addr` |
| redir_req | output | 1 | Redirect request, valid in the fetch cycle |
| redir_target | output | 16 | Handler address for the redirect |

## Verification
A register write can land in the same cycle as a fetch that the write would change. Examples are disabling an entry that matches the fetch, or moving its address. The bench drives the control write and a matching fetch together. It expects the redirect from the old enable in that cycle and no redirect on the following fetch. The error flag can also be set and cleared in the same cycle. The bench clears it while a guarded entry is still enabled and expects the flag to survive. The flag is then cleared only by a second clear once the entry is off.

// File: rtl/rom_patch_pkg.sv
package rom_patch_pkg;

   // enable bit for entry idx sits at an odd position of the control word
   function automatic int unsigned enable_pos(int unsigned idx);
      return 2 * idx + 1;
   endfunction

   // word address of patch entry idx relative to the first entry
   function automatic int unsigned entry_offset(int unsigned idx);
      return 2 * idx;
   endfunction

endpackage

// File: rtl/rpc_entry_cmp.sv
module rpc_entry_cmp #(
   parameter int unsigned     AW       = 16,
   parameter bit              GUARD_EN = 1'b1,
   parameter logic [AW-1:0]   FLOOR    = 16'h0080
) (
   input  logic          en,
   input  logic [AW-1:0] patch_addr,
   input  logic [AW-1:0] fetch_addr,
   output logic          hit,
   output logic          guard_viol
);

   logic below_floor;

   generate
      if (GUARD_EN) begin : g_guard
         assign below_floor = (patch_addr < FLOOR);
      end else begin : g_noguard
         assign below_floor = 1'b0;
      end
   endgenerate

   assign hit        = en & ~below_floor & (patch_addr == fetch_addr);
   assign guard_viol = en & below_floor;

endmodule

// File: rtl/rpc_regfile.sv
module rpc_regfile
   import rom_patch_pkg::*;
#(
   parameter int unsigned   AW         = 16,
   parameter int unsigned   N          = 2,
   parameter int unsigned   CW         = 8,
   parameter int unsigned   ERR_BIT    = 7,
   parameter logic [AW-1:0] PATCH_BASE = 16'hFF38,
   parameter logic [AW-1:0] CTRL_ADDR  = 16'hFF36
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [AW-1:0]        bus_addr,
   input  logic [AW-1:0]        bus_wdata,
   input  logic                 bus_we,
   output logic [AW-1:0]        bus_rdata,
   input  logic                 err_set,
   output logic [N-1:0][AW-1:0] patch_q,
   output logic [N-1:0]         en_q,
   output logic                 err_q
);

   logic          ctrl_wr;
   logic [CW-1:0] ctrl_img;

   assign ctrl_wr = bus_we && (bus_addr == CTRL_ADDR);

   genvar gi;
   generate
      for (gi = 0; gi < N; gi++) begin : g_entry
         localparam logic [AW-1:0] MY_ADDR = PATCH_BASE + AW'(entry_offset(gi));
         localparam int unsigned   EB      = enable_pos(gi);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               patch_q[gi] <= '0;
            end else if (bus_we && (bus_addr == MY_ADDR) && !en_q[gi]) begin
               patch_q[gi] <= bus_wdata;
            end
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               en_q[gi] <= 1'b0;
            end else if (ctrl_wr) begin
               en_q[gi] <= bus_wdata[EB];
            end
         end
      end
   endgenerate

   // sticky error: hardware set wins over a software clear
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         err_q <= 1'b0;
      end else if (err_set) begin
         err_q <= 1'b1;
      end else if (ctrl_wr && bus_wdata[ERR_BIT]) begin
         err_q <= 1'b0;
      end
   end

   always_comb begin
      ctrl_img = '0;
      for (int i = 0; i < N; i++) begin
         ctrl_img[enable_pos(i)] = en_q[i];
      end
      ctrl_img[ERR_BIT] = err_q;
   end

   always_comb begin
      bus_rdata = '0;
      if (bus_addr == CTRL_ADDR) begin
         bus_rdata = AW'(ctrl_img);
      end
      for (int i = 0; i < N; i++) begin
         if (bus_addr == PATCH_BASE + AW'(entry_offset(i))) begin
            bus_rdata = patch_q[i];
         end
      end
   end

endmodule

// File: rtl/rom_patch_cmp.sv
module rom_patch_cmp #(
   parameter int unsigned       ADDR_W      = 16,
   parameter int unsigned       N_ENTRY     = 2,
   parameter int unsigned       CTRL_W      = 8,
   parameter int unsigned       ERR_BIT     = 7,
   parameter bit                GUARD_EN    = 1'b1,
   parameter logic [ADDR_W-1:0] PATCH_BASE  = 16'hFF38,
   parameter logic [ADDR_W-1:0] CTRL_ADDR   = 16'hFF36,
   parameter logic [ADDR_W-1:0] TARGET     = 16'hF7FD,
   parameter logic [ADDR_W-1:0] GUARD_FLOOR = 16'h0080
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [ADDR_W-1:0] bus_wdata,
   input  logic              bus_we,
   output logic [ADDR_W-1:0] bus_rdata,
   input  logic [ADDR_W-1:0] fetch_addr,
   input  logic              fetch_valid,
   output logic              redir_req,
   output logic [ADDR_W-1:0] redir_target
);

   localparam int unsigned TOP_EN_BIT = 2 * N_ENTRY - 1;

   generate
      if (N_ENTRY < 1 || N_ENTRY > 3) begin : g_bad_n
         $error("rom_patch_cmp: N_ENTRY must be 1..3");
      end
      if (TOP_EN_BIT >= CTRL_W || ERR_BIT >= CTRL_W) begin : g_bad_ctrl
         $error("rom_patch_cmp: control bits do not fit CTRL_W");
      end
      if (ERR_BIT % 2 == 1 && ERR_BIT <= TOP_EN_BIT) begin : g_bad_err
         $error("rom_patch_cmp: ERR_BIT collides with an enable bit");
      end
      if (CTRL_W > ADDR_W) begin : g_bad_w
         $error("rom_patch_cmp: CTRL_W wider than the data bus");
      end
   endgenerate

   logic [N_ENTRY-1:0][ADDR_W-1:0] patch_w;
   logic [N_ENTRY-1:0]             en_w;
   logic [N_ENTRY-1:0]             hit_w;
   logic [N_ENTRY-1:0]             viol_w;
   logic                           err_w;

   rpc_regfile #(
      .AW        (ADDR_W),
      .N         (N_ENTRY),
      .CW        (CTRL_W),
      .ERR_BIT   (ERR_BIT),
      .PATCH_BASE(PATCH_BASE),
      .CTRL_ADDR (CTRL_ADDR)
   ) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .bus_addr (bus_addr),
      .bus_wdata(bus_wdata),
      .bus_we   (bus_we),
      .bus_rdata(bus_rdata),
      .err_set  (|viol_w),
      .patch_q  (patch_w),
      .en_q     (en_w),
      .err_q    (err_w)
   );

   genvar gi;
   generate
      for (gi = 0; gi < N_ENTRY; gi++) begin : g_cmp
         rpc_entry_cmp #(
            .AW      (ADDR_W),
            .GUARD_EN(GUARD_EN),
            .FLOOR   (GUARD_FLOOR)
         ) u_cmp (
            .en        (en_w[gi]),
            .patch_addr(patch_w[gi]),
            .fetch_addr(fetch_addr),
            .hit       (hit_w[gi]),
            .guard_viol(viol_w[gi])
         );
      end
   endgenerate

   assign redir_req    = fetch_valid & (|hit_w);
   assign redir_target = TARGET;

endmodule

// File: rtl/rom_patch_cmp_chk.sv
module rom_patch_cmp_chk #(
   parameter int unsigned   AW         = 16,
   parameter int unsigned   N          = 2,
   parameter bit            GUARD_EN   = 1'b1,
   parameter logic [AW-1:0] PATCH_BASE = 16'hFF38,
   parameter logic [AW-1:0] FLOOR      = 16'h0080
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [AW-1:0]        bus_addr,
   input logic                 bus_we,
   input logic                 err_clr,
   input logic [AW-1:0]        fetch_addr,
   input logic                 fetch_valid,
   input logic                 redir_req,
   input logic [N-1:0][AW-1:0] patch,
   input logic [N-1:0]         en,
   input logic                 err
);

   AST_REDIR_NEEDS_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
      redir_req |-> fetch_valid); // R6

   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (err && !err_clr) |=> err); // R8

   genvar gi;
   generate
      if (GUARD_EN) begin : g_guard
         AST_NO_LOW_REDIR: assert property (@(posedge clk) disable iff (!rst_n)
            redir_req |-> (fetch_addr >= FLOOR)); // R7
      end
      for (gi = 0; gi < N; gi++) begin : g_ent
         AST_LOCKED_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
            (en[gi] && bus_we && bus_addr == PATCH_BASE + AW'(2 * gi)) |=> $stable(patch[gi])); // R4

         AST_MATCH_REDIR: assert property (@(posedge clk) disable iff (!rst_n)
            (fetch_valid && en[gi] && fetch_addr == patch[gi] && (!GUARD_EN || patch[gi] >= FLOOR))
            |-> redir_req); // R5
      end
   endgenerate

endmodule

bind rom_patch_cmp rom_patch_cmp_chk #(
   .AW        (ADDR_W),
   .N         (N_ENTRY),
   .GUARD_EN  (GUARD_EN),
   .PATCH_BASE(PATCH_BASE),
   .FLOOR     (GUARD_FLOOR)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .bus_addr   (bus_addr),
   .bus_we     (bus_we),
   .err_clr    (bus_we && bus_addr == CTRL_ADDR && bus_wdata[ERR_BIT]),
   .fetch_addr (fetch_addr),
   .fetch_valid(fetch_valid),
   .redir_req  (redir_req),
   .patch      (patch_w),
   .en         (en_w),
   .err        (err_w)
);

// File: tb/rom_patch_cmp_test.sv
module rom_patch_cmp_test;

   localparam int CLK_P = 10;
   localparam logic [15:0] A_P0   = 16'hFF38;
   localparam logic [15:0] A_P1   = 16'hFF3A;
   localparam logic [15:0] A_CTRL = 16'hFF36;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] bus_addr = '0;
   logic [15:0] bus_wdata = '0;
   logic        bus_we = 1'b0;
   logic [15:0] bus_rdata;
   logic [15:0] fetch_addr = '0;
   logic        fetch_valid = 1'b0;
   logic        redir_req;
   logic [15:0] redir_target;

   int checks = 0;
   int errs = 0;

   logic [15:0] m_patch [2];
   logic        m_en [2];
   logic        m_err;

   always #(CLK_P / 2) clk = ~clk;

   rom_patch_cmp uut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_we(bus_we), .bus_rdata(bus_rdata), .fetch_addr(fetch_addr),
      .fetch_valid(fetch_valid), .redir_req(redir_req), .redir_target(redir_target)
   );

   task automatic check(string req, logic [15:0] act, logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic low_cond();
      for (int i = 0; i < 2; i++)
         if (m_en[i] && m_patch[i] < 16'h0080) return 1'b1;
      return 1'b0;
   endfunction

   function automatic logic exp_hit(logic [15:0] a, logic v);
      if (!v) return 1'b0;
      for (int i = 0; i < 2; i++)
         if (m_en[i] && m_patch[i] == a && m_patch[i] >= 16'h0080) return 1'b1;
      return 1'b0;
   endfunction

   function automatic logic [15:0] exp_read(logic [15:0] a);
      if (a == A_P0) return m_patch[0];
      if (a == A_P1) return m_patch[1];
      if (a == A_CTRL) return {8'h00, m_err, 3'b000, m_en[1], 1'b0, m_en[0], 1'b0};
      return 16'h0000;
   endfunction

   // write one word; a fetch may run in the same cycle and is checked against pre-write state
   task automatic bus_write(logic [15:0] a, logic [15:0] d, logic [15:0] fa, logic fv);
      logic c_old;
      logic e_hit;
      c_old = low_cond();
      e_hit = exp_hit(fa, fv);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_we = 1'b1;
      fetch_addr = fa; fetch_valid = fv;
      #1;
      check(fv ? "R9 redirect during write" : "R6 idle during write", 16'(redir_req), 16'(e_hit));
      @(posedge clk);
      if (a == A_P0 && !m_en[0]) m_patch[0] = d;
      if (a == A_P1 && !m_en[1]) m_patch[1] = d;
      if (a == A_CTRL) begin
         if (d[7]) m_err = 1'b0;
         m_en[0] = d[1];
         m_en[1] = d[3];
      end
      if (c_old) m_err = 1'b1;
      @(negedge clk);
      bus_we = 1'b0; fetch_valid = 1'b0;
      @(posedge clk);
      if (low_cond()) m_err = 1'b1;
   endtask

   task automatic chk_read(logic [15:0] a, string req);
      @(negedge clk);
      bus_addr = a;
      #1;
      check(req, bus_rdata, exp_read(a));
   endtask

   task automatic chk_fetch(logic [15:0] a, logic v, string req);
      @(negedge clk);
      fetch_addr = a; fetch_valid = v;
      #1;
      check(req, 16'(redir_req), 16'(exp_hit(a, v)));
      if (redir_req) check("R5 target", redir_target, 16'hF7FD);
      @(negedge clk);
      fetch_valid = 1'b0;
   endtask

   function automatic logic [15:0] pick_addr();
      case ($urandom_range(0, 5))
         0: return 16'h0010;
         1: return 16'h0050;
         2: return 16'h0080;
         3: return 16'h1234;
         4: return 16'h1236;
         default: return 16'hF000;
      endcase
   endfunction

   initial begin
      #(CLK_P * 150000);
      errs++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

   initial begin
      void'($urandom(32'd1357));
      m_patch[0] = '0; m_patch[1] = '0; m_en[0] = 0; m_en[1] = 0; m_err = 0;
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      // R1 reset state
      chk_read(A_P0, "R1 entry0 reset");
      chk_read(A_P1, "R1 entry1 reset");
      chk_read(A_CTRL, "R1 control reset");
      #1 check("R1 no redirect", 16'(redir_req), 16'h0000);

      // R2 word access and odd addresses
      bus_write(A_P0, 16'h1234, 16'h0000, 1'b0);
      chk_read(A_P0, "R2 entry0 readback");
      bus_write(16'hFF39, 16'h5555, 16'h0000, 1'b0);
      chk_read(A_P0, "R2 odd write ignored");
      chk_read(16'hFF39, "R2 odd address reads zero");
      chk_read(16'hFF3B, "R2 odd address reads zero");

      // R3 unused control bits
      bus_write(A_CTRL, 16'hFF75, 16'h0000, 1'b0);
      chk_read(A_CTRL, "R3 unused bits zero");
      bus_write(A_CTRL, 16'h0002, 16'h0000, 1'b0);
      chk_read(A_CTRL, "R3 enable0 bit1");

      // R5 / R6 matching
      chk_fetch(16'h1234, 1'b1, "R5 enabled match");
      chk_fetch(16'h1234, 1'b0, "R6 no fetch strobe");
      chk_fetch(16'h1236, 1'b1, "R6 no match");

      // R4 locked write
      bus_write(A_P0, 16'h4444, 16'h0000, 1'b0);
      chk_read(A_P0, "R4 locked entry keeps value");
      chk_fetch(16'h1234, 1'b1, "R4 match unchanged");

      // R5 both entries match
      bus_write(A_P1, 16'h1234, 16'h0000, 1'b0);
      chk_fetch(16'h1234, 1'b1, "R6 disabled entry1 alone");
      bus_write(A_CTRL, 16'h000A, 16'h0000, 1'b0);
      chk_fetch(16'h1234, 1'b1, "R5 dual match single request");

      // R7 guard floor
      bus_write(A_CTRL, 16'h0000, 16'h0000, 1'b0);
      bus_write(A_P1, 16'h0050, 16'h0000, 1'b0);
      bus_write(A_CTRL, 16'h0008, 16'h0000, 1'b0);
      chk_fetch(16'h0050, 1'b1, "R7 low entry never matches");
      chk_read(A_CTRL, "R7 error flag set");

      // R8 sticky flag and set-wins clear
      bus_write(A_CTRL, 16'h0088, 16'h0000, 1'b0);
      chk_read(A_CTRL, "R8 clear overridden while enabled");
      bus_write(A_CTRL, 16'h0080, 16'h0000, 1'b0);
      chk_read(A_CTRL, "R8 set wins in disabling cycle");
      bus_write(A_CTRL, 16'h0080, 16'h0000, 1'b0);
      chk_read(A_CTRL, "R8 clear after disable");

      // R9 write and fetch in the same cycle
      bus_write(A_CTRL, 16'h0002, 16'h0000, 1'b0);
      bus_write(A_CTRL, 16'h0000, 16'h1234, 1'b1);
      chk_fetch(16'h1234, 1'b1, "R9 disable visible next cycle");
      bus_write(A_P0, 16'h2000, 16'h1234, 1'b1);
      bus_write(A_CTRL, 16'h0002, 16'h2000, 1'b1);
      chk_fetch(16'h2000, 1'b1, "R9 enable visible next cycle");

      // constrained random mix
      for (int n = 0; n < 400; n++) begin
         case ($urandom_range(0, 5))
            0: bus_write(A_P0, pick_addr(), pick_addr(), 1'($urandom_range(0, 1)));
            1: bus_write(A_P1, pick_addr(), pick_addr(), 1'($urandom_range(0, 1)));
            2: bus_write(A_CTRL, 16'($urandom_range(0, 255)), pick_addr(), 1'($urandom_range(0, 1)));
            3: chk_read(($urandom_range(0, 1) != 0) ? A_CTRL : (($urandom_range(0, 1) != 0) ? A_P0 : A_P1), "R2 random readback");
            default: chk_fetch(pick_addr(), 1'($urandom_range(0, 3) != 0), "R5 random fetch");
         endcase
      end

      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

endmodule